// File: doc/BRIEF.md
# SD/MMC Command Line Engine

This block issues one SD/MMC command on the bidirectional CMD line and gathers the card's answer. Software loads a 32-bit argument, then writes a command word. That word holds the command index, a response request, a long-response select, a CRC-ignore select and a go bit. The engine builds the 48-bit command frame and shifts it out one bit per card-clock strobe. The frame carries a start bit, a host-direction bit, the index, the argument, a CRC7 over the first 40 bits and a stop bit. The engine then releases the line and, when asked to, listens for a 48-bit or 136-bit reply.

The card clock itself is generated elsewhere. The engine receives it as `bit_tick`, a single-cycle strobe once per card-clock period. On every strobe the engine updates what it drives on CMD and samples what it reads from CMD. Results land in four 32-bit response words and in a small sticky status word. Software clears status bits by writing ones to the status address. A busy bit shows that a command is in flight. While it is set, any further command write is dropped.

Register map (`reg_waddr` / `reg_raddr`): 0 argument, 1 command word (reads back the last accepted word), 2 status (write: clear by ones), 3 to 6 response words 0 to 3. Read data appears on `reg_rdata` one clock after the address.

Top module: `sdcmd_engine`

## Requirements
- R1: A write to address 1 whose bit 10 (go) is 1 starts a command when the engine is idle; `cmd_oe` rises on a later strobe.
- R2: The frame is 48 bits, most significant first, one bit per strobe: 0, 1, index[5:0] (word bits 5:0), argument[31:0], CRC7 with polynomial x^7+x^3+1 over the preceding 40 bits, then 1. On the strobe after the stop bit, `cmd_oe` drops and `cmd_out` returns to 1.
- R3: With bit 6 (response request) at 0, finishing the frame sets status bit 3 (sent), and the response words keep their values.
- R4: With bit 6 at 1 and bit 7 at 0, a 48-bit reply with a correct CRC7 over its first 40 bits sets status bit 2 (response received). Word 0 then holds reply bits 39:8, and words 1 to 3 read 0.
- R5: With bits 6 and 7 at 1, a 136-bit reply is taken, and its CRC7 is checked over reply bits 127:8. Word 0 holds reply bits 127:96, word 1 holds 95:64, word 2 holds 63:32 and word 3 holds 31:0.
- R6: After the line is released, CMD is sampled on the following strobes. If the first 64 samples are all 1, status bit 1 (timeout) is set and no reply is taken. A start bit on the 64th sample is still accepted.
- R7: A reply whose CRC7 field (reply bits 7:1) mismatches sets status bit 0 (CRC fail) and not bit 2.
- R8: With word bit 8 (CRC ignore) at 1, a reply with a wrong CRC still sets bit 2 and not bit 0.
- R9: Status bits 3:0 are sticky. A write to address 2 clears exactly the bits written as 1, and leaves the others set.
- R10: Status bit 4 is 1 while a command is in flight. A command write during that time is ignored: no second frame goes out, and the command word reads back unchanged.
- R11: A command write with bit 10 at 0 starts nothing.
- R12: After reset, status reads 0, the response words read 0, `cmd_oe` is 0 and `cmd_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Registered read data, one clock after the address |
| bit_tick | input | 1 | One-cycle strobe per card-clock period |
| cmd_out | output | 1 | Value driven on CMD |
| cmd_oe | output | 1 | CMD output enable |
| cmd_in | input | 1 | Value sampled from CMD |

## Verification
The timeout window is probed at both edges. A start bit on the 64th idle sample must be taken, and a 64th idle sample of 1 must time out; an off-by-one counter fails exactly one of these two cases. CRC coverage differs by reply length. The short form includes the start and direction bits, while the long form skips its first eight bits. A design that uses the wrong span reports CRC failures on good long replies, and one that ignores the CRC-ignore select flags the deliberately corrupted reply. The bench also checks two further points. A command written while busy must not emit a second frame. A partial clear must leave the other sticky bits standing; a design that clears the whole word would lose them.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int FRAME_LEN = 48;
  localparam int LONG_LEN  = 136;
  localparam int RESP_BITS = 128;
  localparam int NUM_RESP  = 4;
  localparam int STS_W     = 4;

  // status word bit positions
  localparam int ST_CRC  = 0;
  localparam int ST_TMO  = 1;
  localparam int ST_RESP = 2;
  localparam int ST_SENT = 3;

  // command word bit positions
  localparam int CW_WANT  = 6;
  localparam int CW_LONG  = 7;
  localparam int CW_NOCRC = 8;
  localparam int CW_GO    = 10;

  typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_SHIFT} rx_state_e;

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_of40(input logic [39:0] d);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc7_step(c, d[i]);
    return c;
  endfunction

endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx import sdcmd_pkg::*; (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        start,
  input  logic [5:0]  idx,
  input  logic [31:0] arg,
  output logic        done,
  output logic        cmd_out,
  output logic        cmd_oe
);

  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  logic [FRAME_LEN-1:0] sh;
  logic [CNT_W-1:0]     cnt;
  logic                 active;
  logic [39:0]          head;
  logic [FRAME_LEN-1:0] frame;

  assign head  = {2'b01, idx, arg};
  assign frame = {head, crc7_of40(head), 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      sh      <= '0;
      cnt     <= '0;
      done    <= 1'b0;
      cmd_out <= 1'b1;
      cmd_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        sh     <= frame;
        cnt    <= '0;
      end else if (active && tick) begin
        if (cnt == CNT_W'(FRAME_LEN)) begin
          active  <= 1'b0;
          cmd_oe  <= 1'b0;
          cmd_out <= 1'b1;
          done    <= 1'b1;
        end else begin
          cmd_out <= sh[FRAME_LEN-1];
          cmd_oe  <= 1'b1;
          sh      <= sh << 1;
          cnt     <= cnt + 1'b1;
        end
      end
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_oe) |-> !cmd_out) else $error("frame did not open with 0"); // R2
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_oe) |-> $past(cmd_out)) else $error("frame did not close with 1"); // R2

endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx import sdcmd_pkg::*; #(
  parameter int TIMEOUT_TICKS = 64
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 start,
  input  logic                 long_sel,
  input  logic                 skip_crc,
  input  logic                 cmd_in,
  output logic                 rx_ok,
  output logic                 rx_bad,
  output logic                 rx_tmo,
  output logic [RESP_BITS-1:0] frame
);

  localparam int TO_W = $clog2(TIMEOUT_TICKS + 1);

  rx_state_e       st;
  logic [TO_W-1:0] wcnt;
  logic [7:0]      k;
  logic [6:0]      crc;
  logic [6:0]      crc_n;
  logic [7:0]      last_k;
  logic            covered;

  assign last_k  = long_sel ? 8'(LONG_LEN - 1) : 8'(FRAME_LEN - 1);
  assign covered = long_sel ? (k >= 8'd8 && k < 8'd128) : (k < 8'd40);
  assign crc_n   = covered ? crc7_step(crc, cmd_in) : crc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= RX_IDLE;
      wcnt   <= '0;
      k      <= '0;
      crc    <= '0;
      frame  <= '0;
      rx_ok  <= 1'b0;
      rx_bad <= 1'b0;
      rx_tmo <= 1'b0;
    end else begin
      rx_ok  <= 1'b0;
      rx_bad <= 1'b0;
      rx_tmo <= 1'b0;
      case (st)
        RX_IDLE: if (start) begin
          st    <= RX_WAIT;
          wcnt  <= '0;
          k     <= '0;
          crc   <= '0;
          frame <= '0;
        end
        RX_WAIT: if (tick) begin
          if (!cmd_in) begin
            st    <= RX_SHIFT;
            frame <= {frame[RESP_BITS-2:0], 1'b0};
            crc   <= crc_n;
            k     <= 8'd1;
          end else if (wcnt == TO_W'(TIMEOUT_TICKS - 1)) begin
            rx_tmo <= 1'b1;
            st     <= RX_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        RX_SHIFT: if (tick) begin
          frame <= {frame[RESP_BITS-2:0], cmd_in};
          crc   <= crc_n;
          k     <= k + 8'd1;
          if (k == last_k) begin
            st <= RX_IDLE;
            if (skip_crc || frame[6:0] == crc) rx_ok  <= 1'b1;
            else                               rx_bad <= 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_ok, rx_bad, rx_tmo})) else $error("two outcomes at once"); // R7
  AST_TMO_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    rx_tmo |-> $past(cmd_in)) else $error("timeout on a low sample"); // R6
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    wcnt <= TO_W'(TIMEOUT_TICKS - 1)) else $error("wait count overran"); // R6

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine import sdcmd_pkg::*; #(
  parameter int TIMEOUT_TICKS = 64,
  parameter int ADDR_W        = 3
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [31:0]       reg_rdata,
  input  logic              bit_tick,
  output logic              cmd_out,
  output logic              cmd_oe,
  input  logic              cmd_in
);

  localparam logic [ADDR_W-1:0] A_ARG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_R0  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_R1  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_R2  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_R3  = ADDR_W'(6);

  logic [31:0]          arg_q;
  logic [31:0]          cmdw_q;
  logic [STS_W-1:0]     sts_q;
  logic [STS_W-1:0]     set_v;
  logic [STS_W-1:0]     clr_v;
  logic                 busy_q;
  logic                 req_want, req_long, req_skip;
  logic [31:0]          resp_q [NUM_RESP];
  logic                 wr_cmd, start;
  logic                 tx_done, rx_ok, rx_bad, rx_tmo;
  logic [RESP_BITS-1:0] rx_frame;

  assign wr_cmd = reg_we && (reg_waddr == A_CMD);
  assign start  = wr_cmd && reg_wdata[CW_GO] && !busy_q;
  assign clr_v  = (reg_we && reg_waddr == A_STS) ? reg_wdata[STS_W-1:0] : '0;

  always_comb begin
    set_v          = '0;
    set_v[ST_CRC]  = rx_bad;
    set_v[ST_TMO]  = rx_tmo;
    set_v[ST_RESP] = rx_ok;
    set_v[ST_SENT] = tx_done && !req_want;
  end

  sdcmd_tx u_tx (
    .clk(clk), .rst(rst), .tick(bit_tick), .start(start),
    .idx(reg_wdata[5:0]), .arg(arg_q), .done(tx_done),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe)
  );

  sdcmd_rx #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_rx (
    .clk(clk), .rst(rst), .tick(bit_tick), .start(tx_done && req_want),
    .long_sel(req_long), .skip_crc(req_skip), .cmd_in(cmd_in),
    .rx_ok(rx_ok), .rx_bad(rx_bad), .rx_tmo(rx_tmo), .frame(rx_frame)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arg_q    <= '0;
      cmdw_q   <= '0;
      sts_q    <= '0;
      busy_q   <= 1'b0;
      req_want <= 1'b0;
      req_long <= 1'b0;
      req_skip <= 1'b0;
    end else begin
      if (reg_we && reg_waddr == A_ARG) arg_q <= reg_wdata;
      sts_q <= (sts_q & ~clr_v) | set_v;
      if (start) begin
        busy_q   <= 1'b1;
        cmdw_q   <= reg_wdata;
        req_want <= reg_wdata[CW_WANT];
        req_long <= reg_wdata[CW_LONG];
        req_skip <= reg_wdata[CW_NOCRC];
      end else if ((tx_done && !req_want) || rx_ok || rx_bad || rx_tmo) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NUM_RESP; w++) resp_q[w] <= '0;
    end else if (rx_ok || rx_bad) begin
      for (int w = 0; w < NUM_RESP; w++) begin
        if (req_long)    resp_q[w] <= rx_frame[RESP_BITS-1-32*w -: 32];
        else if (w == 0) resp_q[w] <= rx_frame[39:8];
        else             resp_q[w] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_raddr)
        A_ARG:   reg_rdata <= arg_q;
        A_CMD:   reg_rdata <= cmdw_q;
        A_STS:   reg_rdata <= {{(32-STS_W-1){1'b0}}, busy_q, sts_q};
        A_R0:    reg_rdata <= resp_q[0];
        A_R1:    reg_rdata <= resp_q[1];
        A_R2:    reg_rdata <= resp_q[2];
        A_R3:    reg_rdata <= resp_q[3];
        default: reg_rdata <= '0;
      endcase
    end
  end

  AST_OE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_oe |-> busy_q) else $error("line driven while idle"); // R10
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (busy_q && wr_cmd) |=> $stable(cmdw_q)) else $error("command taken while busy"); // R10

  for (genvar b = 0; b < STS_W; b++) begin : g_sticky
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (sts_q[b] && !clr_v[b]) |=> sts_q[b]) else $error("status bit lost"); // R9
  end

endmodule

// File: tb/sim_sdcmd_engine.sv
module sim_sdcmd_engine;

  localparam int TMO = 64;
  localparam int NV  = 7;
  // idx[49:44] arg[43:12] mode[11:10] (0 none,1 short,2 long) delay[9:2] badcrc[1] skipcrc[0]
  localparam logic [49:0] VEC [NV] = '{
    {6'd17, 32'h0000_0200, 2'd1, 8'd2,  1'b0, 1'b0},
    {6'd0,  32'h0000_0000, 2'd0, 8'd0,  1'b0, 1'b0},
    {6'd2,  32'h0000_0000, 2'd2, 8'd5,  1'b0, 1'b0},
    {6'd13, 32'h1234_5678, 2'd1, 8'd1,  1'b1, 1'b0},
    {6'd41, 32'h00FF_8000, 2'd1, 8'd0,  1'b1, 1'b1},
    {6'd8,  32'h0000_01AA, 2'd1, 8'd63, 1'b0, 1'b0},
    {6'd55, 32'hDEAD_BEEF, 2'd1, 8'd64, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        bit_tick = 1'b0;
  logic        cmd_out, cmd_oe;
  logic        cmd_in = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sdcmd_engine u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .bit_tick(bit_tick), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  end

  function automatic logic [6:0] ref_crc(input logic [127:0] d, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(posedge clk);
    while (!bit_tick) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_raddr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] cmd_word(input logic [5:0] idx, input logic want,
                                           input logic lng, input logic skp, input logic go);
    return {21'b0, go, 1'b0, skp, lng, want, idx};
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] last_r0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(3'd2, d); chk(d == 32'h0, "R12", 64'(d), 64'h0);
    rd(3'd3, d); chk(d == 32'h0, "R12", 64'(d), 64'h0);
    chk(cmd_oe == 1'b0 && cmd_out == 1'b1, "R12", {62'b0, cmd_oe, cmd_out}, 64'h1);
    last_r0 = 32'h0;

    // table walk
    for (int e = 0; e < NV; e++) begin
      logic [49:0]  v;
      logic [5:0]   idx;
      logic [31:0]  arg;
      logic [1:0]   mode;
      int           dly;
      logic         bad, skp, seen;
      logic [47:0]  got, expf;
      logic [39:0]  head;
      logic [135:0] rf;
      logic [31:0]  pay32;
      logic [119:0] pay120;
      logic [6:0]   c;
      logic [31:0]  exp_r [4];
      logic [31:0]  exp_sts;
      string        tag;
      int           len, guard;
      v = VEC[e];
      idx = v[49:44]; arg = v[43:12]; mode = v[11:10]; dly = int'(v[9:2]);
      bad = v[1]; skp = v[0];

      wr(3'd0, arg);
      wr(3'd1, cmd_word(idx, mode != 2'd0, mode == 2'd2, skp, 1'b1));
      guard = 0;
      seen = 1'b0;
      while (!seen && guard < 20) begin
        wait_tick();
        seen = cmd_oe;
        guard++;
      end
      chk(seen, "R1", 64'(seen), 64'h1);
      got[47] = cmd_out;
      for (int i = 46; i >= 0; i--) begin
        wait_tick();
        got[i] = cmd_out;
      end
      head = {2'b01, idx, arg};
      expf = {head, ref_crc({88'b0, head}, 40), 1'b1};
      chk(got == expf, "R2", 64'(got), 64'(expf));
      wait_tick();
      chk(cmd_oe == 1'b0 && cmd_out == 1'b1, "R2", {62'b0, cmd_oe, cmd_out}, 64'h1);

      pay32  = arg ^ 32'h5A5A_0F0F;
      pay120 = {arg, ~arg, arg ^ 32'h0F0F_F0F0, arg[23:0]};
      if (mode == 2'd2) begin
        c   = ref_crc({8'b0, pay120}, 120);
        rf  = {8'b0011_1111, pay120, c, 1'b1};
        len = 136;
        for (int w = 0; w < 4; w++) exp_r[w] = rf[127-32*w -: 32];
      end else begin
        c   = ref_crc({88'b0, 2'b00, idx, pay32}, 40) ^ (bad ? 7'h01 : 7'h00);
        rf  = {88'b0, 2'b00, idx, pay32, c, 1'b1};
        len = 48;
        exp_r[0] = pay32; exp_r[1] = '0; exp_r[2] = '0; exp_r[3] = '0;
      end

      if (mode == 2'd0) begin
        exp_sts = 32'h8; tag = "R3";
      end else if (dly >= TMO) begin
        exp_sts = 32'h2; tag = "R6";
      end else if (bad && !skp) begin
        exp_sts = 32'h1; tag = "R7";
      end else if (bad && skp) begin
        exp_sts = 32'h4; tag = "R8";
      end else if (mode == 2'd2) begin
        exp_sts = 32'h4; tag = "R5";
      end else begin
        exp_sts = 32'h4; tag = (dly == TMO - 1) ? "R6" : "R4";
      end

      if (mode != 2'd0) begin
        for (int k = 0; k < dly; k++) begin
          cmd_in = 1'b1;
          wait_tick();
        end
        if (dly < TMO) begin
          for (int j = len - 1; j >= 0; j--) begin
            cmd_in = rf[j];
            wait_tick();
          end
        end
        cmd_in = 1'b1;
      end
      repeat (3) @(negedge clk);
      rd(3'd2, d);
      chk(d == exp_sts, tag, 64'(d), 64'(exp_sts));
      if (mode == 2'd0) begin
        rd(3'd3, d);
        chk(d == last_r0, "R3", 64'(d), 64'(last_r0));
      end else if (dly < TMO) begin
        for (int w = 0; w < 4; w++) begin
          rd(3'(3 + w), d);
          chk(d == exp_r[w], tag, 64'(d), 64'(exp_r[w]));
        end
        last_r0 = exp_r[0];
      end
      wr(3'd2, 32'h0000_001F);
      rd(3'd2, d);
      chk(d == 32'h0, "R9", 64'(d), 64'h0);
    end

    // R11: command word without the go bit
    begin
      int rises = 0;
      wr(3'd1, cmd_word(6'd3, 1'b0, 1'b0, 1'b0, 1'b0));
      for (int t = 0; t < 60; t++) begin
        wait_tick();
        if (cmd_oe) rises++;
      end
      chk(rises == 0, "R11", 64'(rises), 64'h0);
      rd(3'd2, d);
      chk(d == 32'h0, "R11", 64'(d), 64'h0);
    end

    // R10: busy flag and dropped second command
    begin
      int rises = 0;
      logic prev = 1'b0;
      wr(3'd0, 32'h0000_0042);
      wr(3'd1, cmd_word(6'd5, 1'b0, 1'b0, 1'b0, 1'b1));
      rd(3'd2, d);
      chk(d[4] == 1'b1, "R10", 64'(d), 64'h10);
      wr(3'd1, cmd_word(6'd6, 1'b1, 1'b0, 1'b0, 1'b1));
      for (int t = 0; t < 150; t++) begin
        wait_tick();
        if (cmd_oe && !prev) rises++;
        prev = cmd_oe;
      end
      chk(rises == 1, "R10", 64'(rises), 64'h1);
      rd(3'd2, d);
      chk(d == 32'h8, "R10", 64'(d), 64'h8);
      rd(3'd1, d);
      chk(d == cmd_word(6'd5, 1'b0, 1'b0, 1'b0, 1'b1), "R10", 64'(d),
          64'(cmd_word(6'd5, 1'b0, 1'b0, 1'b0, 1'b1)));
    end

    // R9: partial clear keeps other sticky bits (sent still set, add a timeout)
    wr(3'd1, cmd_word(6'd9, 1'b1, 1'b0, 1'b0, 1'b1));
    for (int t = 0; t < 130; t++) wait_tick();
    rd(3'd2, d);
    chk(d == 32'hA, "R9", 64'(d), 64'hA);
    wr(3'd2, 32'h0000_0002);
    rd(3'd2, d);
    chk(d == 32'h8, "R9", 64'(d), 64'h8);
    wr(3'd2, 32'h0000_0008);
    rd(3'd2, d);
    chk(d == 32'h0, "R9", 64'(d), 64'h0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule